// File: doc/BRIEF.md
# Preset Event Counter with Status Word

The block counts single-cycle event pulses into a signed accumulator and compares it with a signed high preset. It exposes three 16-bit words to a host: a status word, the preset and the accumulator. A counting mode selects up-only or up/down counting. An enable input gates the counting and is mirrored into the status word.

When a counting step lands the accumulator on the preset, or wraps it past either signed limit, the block raises an interrupt request. It records the event that caused the request, and it flags a lost interrupt when a second event arrives before the first has been serviced. Software clears the latched bits through a write-one-to-clear mask. It can also overwrite the accumulator through a two-cycle load handshake, and a configure pulse puts the status word into its start-up state.

Status bit positions, from bit 15 down to bit 1: count-up enable (15), count-down enable (14), preset-reached latch (13), overflow (12), underflow (11), load-in-progress (10), accumulator-at-or-above-preset (9), low-preset (8, reads 0), overflow cause (7), underflow cause (6), preset cause (5), low-preset cause (4, reads 0), interrupt pending (3), interrupt lost (2), interrupt enable (1). Bit 0 reads 0.

Top module: `preset_event_counter`

## Requirements
- R1: After `rst_n` is released, the accumulator and preset read 0, `irq` is 0, and the status word reads 16'h0200: only bit 9 is set, because 0 >= 0.
- R2: After a cycle with `cfg_init` high, status bits 15, 14, 7, 6, 5 and 3 read 0 and bit 1 reads 1. Bits 13, 12, 11 and 2 keep their values.
- R3: Outside a `cfg_init` cycle, bit 15 equals the value `run_en` had in the previous cycle, in every mode. Setting bit 15 in `clr_mask` has no effect on it.
- R4: Bit 14 equals the previous cycle's `run_en` while `mode` is 3 to 8, and reads 0 for any other mode. Setting bit 14 in `clr_mask` has no effect on it.
- R5: While `run_en` is high, modes 1 and 2 add 1 for each `cnt_up` cycle and ignore `cnt_dn`. Modes 3 to 8 add 1 on `cnt_up` and subtract 1 on `cnt_dn`, and leave the accumulator unchanged when both are high. Modes 0 and 9 to 15, and any cycle with `run_en` low, do not count.
- R6: An up step from +32767 gives -32768 and sets bit 12. A down step from -32768 gives +32767 and sets bit 11.
- R7: In modes 1 and 2, bit 13 sets when a count step makes the accumulator equal to the preset, and stays set until it is cleared. In any other mode, bit 13 reads 0.
- R8: When bit 1 is set, bit 3 is clear, and a preset, overflow or underflow event occurs, the block sets bit 3 and `irq`. Bits 5, 7 and 6 are then loaded with exactly the preset, overflow and underflow events of that cycle.
- R9: When an event occurs while bits 1 and 3 are both set, bit 2 sets, and bits 3, 5, 6 and 7 keep their values.
- R10: Writing `clr_mask` with `clr_we` high clears any of bits 13, 12, 11, 3 and 2 whose mask bit is 1. A clear of bit 3 drops `irq` in the next cycle.
- R11: A `ld_req` cycle sets bit 10 for one cycle. In the cycle after that, the accumulator holds `ld_val` and bit 10 reads 0.
- R12: Bit 9 reads 1 exactly when the accumulator, taken as signed, is at least the preset, taken as signed. Bits 8, 4 and 0 always read 0.
- R13: An `acc_zero` cycle with no load in progress sets the accumulator to 0 and clears bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_init | input | 1 | Configure pulse: puts the status word into its start-up state |
| run_en | input | 1 | Counting enable |
| mode | input | 4 | Counting mode: 1-2 up only, 3-8 up/down, others idle |
| cnt_up | input | 1 | Up-count event, one per cycle high |
| cnt_dn | input | 1 | Down-count event, one per cycle high |
| acc_zero | input | 1 | Zero the accumulator and clear the preset-reached latch |
| ld_req | input | 1 | Request to load the accumulator |
| ld_val | input | W | Value for an accumulator load |
| pre_we | input | 1 | Preset write strobe |
| pre_val | input | W | New preset value |
| clr_we | input | 1 | Clear-mask write strobe |
| clr_mask | input | 16 | Write-one-to-clear mask for the status word |
| status_word | output | 16 | Status word |
| preset_word | output | W | Preset value |
| acc_word | output | W | Accumulator value |
| irq | output | 1 | Interrupt request; equals status bit 3 |

## Verification
The assertions take for granted that the host never pulses `cfg_init` in the same cycle as an event it wants to see recorded, and never asks for a new load while a load is still in progress. The lost-flag and pending-clear properties therefore exclude `cfg_init` cycles and clear writes that coincide with an event. The stimulus drives every command for exactly one cycle from a quiet state and waits until each load has finished before it counts again. It reaches the preset and the signed limits only through deliberate loads, so the full mode-by-pulse sweep never raises an event by accident.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    localparam int unsigned SW = 16;   // status word width, fixed by the layout

    // status bit positions
    localparam int unsigned B_CU  = 15;
    localparam int unsigned B_CD  = 14;
    localparam int unsigned B_DN  = 13;
    localparam int unsigned B_OV  = 12;
    localparam int unsigned B_UN  = 11;
    localparam int unsigned B_LD  = 10;
    localparam int unsigned B_HP  = 9;
    localparam int unsigned B_OVC = 7;
    localparam int unsigned B_UNC = 6;
    localparam int unsigned B_HIC = 5;
    localparam int unsigned B_PE  = 3;
    localparam int unsigned B_LS  = 2;
    localparam int unsigned B_IE  = 1;

    // bits the host is allowed to clear
    localparam logic [SW-1:0] CLR_OK = (SW'(1) << B_DN) | (SW'(1) << B_OV) |
                                       (SW'(1) << B_UN) | (SW'(1) << B_PE) |
                                       (SW'(1) << B_LS);

    typedef struct packed {
        logic hit;   // a count step landed on the preset
        logic ovf;   // up step wrapped past the positive limit
        logic unf;   // down step wrapped past the negative limit
    } pcnt_evt_t;

    function automatic logic is_up_mode(input logic [3:0] m);
        return (m == 4'd1) || (m == 4'd2);
    endfunction

    function automatic logic is_bidir_mode(input logic [3:0] m);
        return (m >= 4'd3) && (m <= 4'd8);
    endfunction

endpackage

// File: rtl/pcnt_acc.sv
module pcnt_acc
    import pcnt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [3:0]   mode,
    input  logic         cnt_up,
    input  logic         cnt_dn,
    input  logic         acc_zero,
    input  logic         ld_req,
    input  logic [W-1:0] ld_val,
    input  logic         pre_we,
    input  logic [W-1:0] pre_val,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] pre_q,
    output logic         ld_busy,
    output pcnt_evt_t    evt
);

    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] pre;
        logic [W-1:0] hold;
        logic         ld;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic    inc, dec;

    always_comb begin
        inc  = run_en && (is_up_mode(mode) || is_bidir_mode(mode)) && cnt_up;
        dec  = run_en && is_bidir_mode(mode) && cnt_dn;
        st_d = st_q;
        evt  = '0;
        if (pre_we) st_d.pre = pre_val;
        st_d.ld   = ld_req;
        st_d.hold = ld_req ? ld_val : st_q.hold;
        if (st_q.ld) begin
            st_d.acc = st_q.hold;
        end else if (acc_zero) begin
            st_d.acc = '0;
        end else if (inc && !dec) begin
            st_d.acc = st_q.acc + ONE;
            evt.ovf  = (st_q.acc == MAXV);
            evt.hit  = ((st_q.acc + ONE) == st_q.pre);
        end else if (dec && !inc) begin
            st_d.acc = st_q.acc - ONE;
            evt.unf  = (st_q.acc == MINV);
            evt.hit  = ((st_q.acc - ONE) == st_q.pre);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q   = st_q.acc;
    assign pre_q   = st_q.pre;
    assign ld_busy = st_q.ld;

    // R6
    no_overflow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.ovf |=> (acc_q == MINV));
    // R6
    no_underflow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.unf |=> (acc_q == MAXV));
    // R11
    ld_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_busy) |=> ##1 (acc_q == $past(ld_val, 2)));

endmodule

// File: rtl/pcnt_status.sv
module pcnt_status
    import pcnt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_init,
    input  logic          run_en,
    input  logic [3:0]    mode,
    input  pcnt_evt_t     evt,
    input  logic          acc_zero,
    input  logic          clr_we,
    input  logic [SW-1:0] clr_mask,
    input  logic          ld_busy,
    input  logic          at_or_above,
    output logic [SW-1:0] status_word,
    output logic          irq
);

    typedef struct packed {
        logic cu, cd, dn, ov, un;
        logic ovc, unc, hic;
        logic pe, ls, ie;
    } stat_t;

    stat_t         st_d, st_q;
    logic [SW-1:0] clr_eff;
    logic          any_evt;
    logic          unused_clr;

    assign clr_eff    = clr_we ? (clr_mask & CLR_OK) : '0;
    assign unused_clr = ^{clr_eff[15:14], clr_eff[10:4], clr_eff[1:0]};
    assign any_evt    = evt.hit || evt.ovf || evt.unf;

    always_comb begin
        st_d    = st_q;
        st_d.cu = run_en;
        st_d.cd = run_en && is_bidir_mode(mode);
        if (clr_eff[B_DN]) st_d.dn = 1'b0;
        if (clr_eff[B_OV]) st_d.ov = 1'b0;
        if (clr_eff[B_UN]) st_d.un = 1'b0;
        if (clr_eff[B_PE]) st_d.pe = 1'b0;
        if (clr_eff[B_LS]) st_d.ls = 1'b0;
        if (acc_zero)      st_d.dn = 1'b0;
        if (evt.hit)       st_d.dn = 1'b1;
        if (!is_up_mode(mode)) st_d.dn = 1'b0;
        if (evt.ovf)       st_d.ov = 1'b1;
        if (evt.unf)       st_d.un = 1'b1;
        if (st_q.ie && any_evt) begin
            if (st_q.pe && !clr_eff[B_PE]) begin
                st_d.ls = 1'b1;
            end else begin
                st_d.pe  = 1'b1;
                st_d.ovc = evt.ovf;
                st_d.unc = evt.unf;
                st_d.hic = evt.hit;
            end
        end
        if (cfg_init) begin
            st_d.cu  = 1'b0;
            st_d.cd  = 1'b0;
            st_d.pe  = 1'b0;
            st_d.ovc = 1'b0;
            st_d.unc = 1'b0;
            st_d.hic = 1'b0;
            st_d.ie  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_word = {st_q.cu, st_q.cd, st_q.dn, st_q.ov, st_q.un, ld_busy,
                          at_or_above, 1'b0, st_q.ovc, st_q.unc, st_q.hic, 1'b0,
                          st_q.pe, st_q.ls, st_q.ie, 1'b0};
    assign irq = st_q.pe;

    // R2
    init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_init |=> (status_word[B_IE] && !irq && status_word[15:14] == 2'b00
                      && status_word[7:5] == 3'b000));
    // R3
    cu_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_init |=> (status_word[B_CU] == $past(run_en)));
    // R4
    cd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_bidir_mode(mode) |=> !status_word[B_CD]);
    // R7
    dn_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_up_mode(mode) |=> !status_word[B_DN]);
    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[B_IE] && !irq && evt.hit && !cfg_init) |=> (irq && status_word[B_HIC]));
    // R9
    lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status_word[B_IE] && any_evt && !(clr_we && clr_mask[B_PE]) && !cfg_init)
        |=> (status_word[B_LS] && irq));
    // R10
    pe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[B_PE] && !any_evt) |=> !irq);

endmodule

// File: rtl/preset_event_counter.sv
module preset_event_counter
    import pcnt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_init,
    input  logic          run_en,
    input  logic [3:0]    mode,
    input  logic          cnt_up,
    input  logic          cnt_dn,
    input  logic          acc_zero,
    input  logic          ld_req,
    input  logic [W-1:0]  ld_val,
    input  logic          pre_we,
    input  logic [W-1:0]  pre_val,
    input  logic          clr_we,
    input  logic [SW-1:0] clr_mask,
    output logic [SW-1:0] status_word,
    output logic [W-1:0]  preset_word,
    output logic [W-1:0]  acc_word,
    output logic          irq
);

    pcnt_evt_t evt;
    logic      ld_busy;
    logic      at_or_above;

    pcnt_acc #(.W(W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .mode     (mode),
        .cnt_up   (cnt_up),
        .cnt_dn   (cnt_dn),
        .acc_zero (acc_zero),
        .ld_req   (ld_req),
        .ld_val   (ld_val),
        .pre_we   (pre_we),
        .pre_val  (pre_val),
        .acc_q    (acc_word),
        .pre_q    (preset_word),
        .ld_busy  (ld_busy),
        .evt      (evt)
    );

    assign at_or_above = ($signed(acc_word) >= $signed(preset_word));

    pcnt_status stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_init    (cfg_init),
        .run_en      (run_en),
        .mode        (mode),
        .evt         (evt),
        .acc_zero    (acc_zero),
        .clr_we      (clr_we),
        .clr_mask    (clr_mask),
        .ld_busy     (ld_busy),
        .at_or_above (at_or_above),
        .status_word (status_word),
        .irq         (irq)
    );

    // R12
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[8] == 1'b0) && (status_word[4] == 1'b0) && (status_word[0] == 1'b0));

endmodule

// File: tb/preset_event_counter_tb_top.sv
`timescale 1ns/1ps
module preset_event_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_init = 0, run_en = 0, cnt_up = 0, cnt_dn = 0, acc_zero = 0;
    logic        ld_req = 0, pre_we = 0, clr_we = 0;
    logic [3:0]  mode = '0;
    logic [15:0] ld_val = '0, pre_val = '0, clr_mask = '0;
    logic [15:0] status_word, preset_word, acc_word;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int exp_acc;

    always #4 clk = ~clk;

    preset_event_counter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .run_en(run_en), .mode(mode),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .acc_zero(acc_zero), .ld_req(ld_req),
        .ld_val(ld_val), .pre_we(pre_we), .pre_val(pre_val), .clr_we(clr_we),
        .clr_mask(clr_mask), .status_word(status_word), .preset_word(preset_word),
        .acc_word(acc_word), .irq(irq)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [15:0] act, input logic [15:0] exp);
        chk(act === exp, req, int'(act), int'(exp));
    endtask

    task automatic chk_bit(input string req, input int idx, input logic exp);
        chk(status_word[idx] === exp, req, int'(status_word[idx]), int'(exp));
    endtask

    task automatic load_acc(input logic [15:0] v);
        ld_req = 1; ld_val = v;
        tick();
        ld_req = 0;
        tick();
    endtask

    task automatic step_up;
        cnt_up = 1; tick(); cnt_up = 0;
    endtask

    task automatic step_dn;
        cnt_dn = 1; tick(); cnt_dn = 0;
    endtask

    task automatic clear(input logic [15:0] m);
        clr_we = 1; clr_mask = m; tick(); clr_we = 0; clr_mask = '0;
    endtask

    task automatic set_preset(input logic [15:0] v);
        pre_we = 1; pre_val = v; tick(); pre_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_word("R1 status", status_word, 16'h0200);
        chk_word("R1 acc", acc_word, 16'h0000);
        chk_word("R1 preset", preset_word, 16'h0000);
        chk(irq === 1'b0, "R1 irq", int'(irq), 0);

        // R2 configure: only IE and HP
        cfg_init = 1; tick(); cfg_init = 0;
        chk_word("R2 init status", status_word, 16'h0202);

        // R12 preset above accumulator clears HP
        set_preset(16'd1000);
        chk_bit("R12 hp low", 9, 1'b0);

        // R5 R3 R4: sweep every mode, pulse pattern and enable
        exp_acc = 0;
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 4; p++) begin
                for (int e = 0; e < 2; e++) begin
                    logic up_m, bi_m, inc, dec;
                    up_m = (m == 1) || (m == 2);
                    bi_m = (m >= 3) && (m <= 8);
                    inc  = (e == 1) && (up_m || bi_m) && p[0];
                    dec  = (e == 1) && bi_m && p[1];
                    if (inc && !dec) exp_acc++;
                    if (dec && !inc) exp_acc--;
                    mode = 4'(m); run_en = e[0]; cnt_up = p[0]; cnt_dn = p[1];
                    tick();
                    cnt_up = 0; cnt_dn = 0;
                    chk_word("R5 sweep acc", acc_word, 16'(exp_acc));
                    chk_bit("R3 cu follow", 15, e[0]);
                    chk_bit("R4 cd follow", 14, e[0] && bi_m);
                end
            end
        end
        chk(irq === 1'b0, "R8 no event in sweep", int'(irq), 0);

        // R3 R4 host writes to CU/CD are ignored
        mode = 4'd3; run_en = 1;
        tick();
        clear(16'hC000);
        chk_bit("R3 cu write ignored", 15, 1'b1);
        chk_bit("R4 cd write ignored", 14, 1'b1);

        // R11 load handshake
        mode = 4'd1;
        ld_req = 1; ld_val = 16'd32765; tick(); ld_req = 0;
        chk_bit("R11 load flag set", 10, 1'b1);
        chk_word("R11 acc not yet loaded", acc_word, 16'(exp_acc));
        tick();
        chk_bit("R11 load flag clear", 10, 1'b0);
        chk_word("R11 acc loaded", acc_word, 16'd32765);

        // R6 R8 overflow raises interrupt
        step_up(); step_up();
        chk_word("R6 at max", acc_word, 16'h7FFF);
        chk(irq === 1'b0, "R8 no irq before wrap", int'(irq), 0);
        step_up();
        chk_word("R6 wrapped", acc_word, 16'h8000);
        chk_bit("R6 ov bit", 12, 1'b1);
        chk(irq === 1'b1, "R8 irq on ovf", int'(irq), 1);
        chk_bit("R8 ov cause", 7, 1'b1);
        chk_bit("R8 hit cause", 5, 1'b0);

        // R7 R9 preset hit while pending
        load_acc(16'd998);
        step_up();
        chk_bit("R7 dn not yet", 13, 1'b0);
        step_up();
        chk_word("R7 acc at preset", acc_word, 16'd1000);
        chk_bit("R7 dn latched", 13, 1'b1);
        chk_bit("R9 lost set", 2, 1'b1);
        chk_bit("R9 cause kept", 5, 1'b0);
        chk_bit("R9 ov cause kept", 7, 1'b1);
        step_up();
        chk_bit("R7 dn holds", 13, 1'b1);
        load_acc(16'd1000);

        // R2 configure keeps retentive bits
        cfg_init = 1; tick(); cfg_init = 0;
        chk_word("R2 retain", status_word, 16'h3206);
        chk(irq === 1'b0, "R2 irq cleared", int'(irq), 0);

        // R10 clear DN, OV, LS
        clear(16'h3004);
        chk_word("R10 cleared", status_word, 16'h8202);

        // R6 R8 underflow in up/down mode
        mode = 4'd4;
        load_acc(16'h8001);
        step_dn();
        chk_word("R6 at min", acc_word, 16'h8000);
        chk_bit("R6 no un yet", 11, 1'b0);
        step_dn();
        chk_word("R6 wrapped low", acc_word, 16'h7FFF);
        chk_bit("R6 un bit", 11, 1'b1);
        chk(irq === 1'b1, "R8 irq on unf", int'(irq), 1);
        chk_bit("R8 un cause", 6, 1'b1);
        chk_bit("R8 ov cause cleared", 7, 1'b0);

        // R10 pending clear drops irq
        clear(16'h0008);
        chk(irq === 1'b0, "R10 irq dropped", int'(irq), 0);

        // R7 R8 hit in up/down mode: no latch, cause recorded
        mode = 4'd5;
        set_preset(16'd10);
        load_acc(16'd9);
        step_up();
        chk_bit("R7 dn reserved", 13, 1'b0);
        chk(irq === 1'b1, "R8 irq on hit", int'(irq), 1);
        chk_bit("R8 hit cause", 5, 1'b1);
        chk_bit("R8 un cause cleared", 6, 1'b0);
        clear(16'h0008);

        // R13 zeroing
        mode = 4'd1;
        set_preset(16'd5);
        load_acc(16'd4);
        step_up();
        chk_bit("R13 dn before zero", 13, 1'b1);
        acc_zero = 1; tick(); acc_zero = 0;
        chk_word("R13 acc zero", acc_word, 16'h0000);
        chk_bit("R13 dn cleared", 13, 1'b0);

        // R12 signed compare
        set_preset(16'hFFFB);
        chk_bit("R12 hp above negative preset", 9, 1'b1);
        load_acc(16'hFFFA);
        chk_bit("R12 hp below negative preset", 9, 1'b0);
        chk(status_word[8] === 1'b0 && status_word[4] === 1'b0 && status_word[0] === 1'b0,
            "R12 zero bits", int'({status_word[8], status_word[4], status_word[0]}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule